// File: doc/BRIEF.md
# Predicated Multi-Lane Vector Unit

This unit runs integer vector arithmetic on a bank of vector registers. Each register is cut into element slots that are dealt out round-robin to parallel lanes, so element `i` sits in lane `i mod NLANE`. Every lane gets the same control in the same cycle and owns its own partition of every register. Lanes never exchange data. One decoded instruction is taken at a time: add, subtract, multiply, or a not-equal compare that writes a bit mask. The A operand is either a vector register or a broadcast scalar.

A vector-length register sets how many elements an instruction covers. It is latched when the instruction is accepted. The unit then walks the element groups, one group of NLANE elements per cycle. Each write can be gated by one of the mask registers, or the instruction can run unmasked. A side port writes and reads single elements while the unit is idle; it stands in for the load/store path. A mask read port exposes whole mask registers.

The instruction input is valid/ready. `in_ready` is high only while the unit is idle. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. A source must hold its fields steady until that edge. While the unit is busy, `in_ready` stays low and the held instruction waits; nothing is dropped.

Top module: `vx_unit`

## Requirements
- R1: After reset the vector length reads 32 on `vl_cur`. A write on `vl_we` stores `vl_wdata`, and any value above 32 is stored as 32.
- R2: With `in_sv`=0, operation code 0 writes va+vb, code 1 writes va−vb and code 2 writes the low 64 bits of va×vb into vd, element by element.
- R3: With `in_sv`=1, `in_scalar` takes the place of every A element, so the result is scalar op vb[i].
- R4: Operation code 3 writes bit i of mask register `in_vd` with 1 where operand A element i differs from vb[i], and with 0 otherwise.
- R5: With `in_msel[3]`=0, only elements whose bit in mask register `in_msel[2:0]` is 1 are written, by arithmetic or compare. With `in_msel[3]`=1 every element below the length is written.
- R6: Elements and mask bits at index VL or above keep their old values.
- R7: An instruction with VL>0 keeps `in_ready` low for ceil(VL/4) cycles after acceptance. `done` is high for the one cycle after the last group is written, and `in_ready` rises in that same cycle.
- R8: An instruction accepted with VL=0 writes nothing, and `done` is high in the next cycle.
- R9: Reset clears all vector and mask registers. An element write on `hw_en` takes effect while idle and is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_we | input | 1 | Vector-length write strobe |
| vl_wdata | input | 6 | New vector length (clamped to 32) |
| vl_cur | output | 6 | Current vector length |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Unit idle, instruction can be taken |
| in_op | input | 2 | 0 add, 1 sub, 2 mul, 3 compare not-equal |
| in_sv | input | 1 | 1 selects scalar A operand |
| in_vd | input | 3 | Destination vector (or mask for compare) |
| in_va | input | 3 | Source vector A |
| in_vb | input | 3 | Source vector B |
| in_scalar | input | 64 | Scalar A operand |
| in_msel | input | 4 | Bit 3 = unmasked, bits 2:0 = mask register |
| done | output | 1 | One-cycle completion pulse |
| hw_en | input | 1 | Element write strobe (idle only) |
| hw_reg | input | 3 | Element write register |
| hw_idx | input | 5 | Element write index |
| hw_data | input | 64 | Element write data |
| rd_reg | input | 3 | Element read register |
| rd_idx | input | 5 | Element read index |
| rd_data | output | 64 | Element read data |
| rd_mreg | input | 3 | Mask read register |
| rd_mask | output | 32 | Mask read data |

## Verification
The hardest case to reach is an element write arriving while a long instruction is in flight. To get there, the bench starts a full-length instruction. A few cycles after acceptance, while `in_ready` is low, it pokes an element of an unrelated register through the write port, then confirms that element is unchanged once `done` arrives. Masked writes need a mask that is neither all ones nor all zeros. The bench builds one by comparing two registers filled so that every third element matches, then runs a masked subtract with it. A later short compare into the same mask checks that the upper bits are kept.

// File: rtl/vx_pkg.sv
package vx_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_MUL   = 2'd2,
    OP_CMPNE = 2'd3
  } vx_op_e;
endpackage

// File: rtl/vx_lane.sv
module vx_lane
  import vx_pkg::*;
#(
  parameter int LANE  = 0,
  parameter int NLANE = 4,
  parameter int MVL   = 32,
  parameter int EW    = 64,
  parameter int NVREG = 8,
  localparam int SLOTS = MVL / NLANE,
  localparam int GW    = $clog2(SLOTS),
  localparam int RW    = $clog2(NVREG),
  localparam int VLW   = $clog2(MVL) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_en,
  input  logic [GW-1:0]   grp,
  input  logic [VLW-1:0]  vl,
  input  vx_op_e          op,
  input  logic            sv,
  input  logic [RW-1:0]   vd,
  input  logic [RW-1:0]   va,
  input  logic [RW-1:0]   vb,
  input  logic [EW-1:0]   scalar,
  input  logic            mbit,
  input  logic            hw_en,
  input  logic [RW-1:0]   hw_reg,
  input  logic [GW-1:0]   hw_slot,
  input  logic [EW-1:0]   hw_data,
  input  logic [RW-1:0]   rd_reg,
  input  logic [GW-1:0]   rd_slot,
  output logic [EW-1:0]   rd_data,
  output logic            cmp_bit,
  output logic            cmp_act
);
  logic [EW-1:0] rf [NVREG][SLOTS];
  logic [EW-1:0] a_el, b_el, opa, res;
  logic          in_len, active;

  assign a_el   = rf[va][grp];
  assign b_el   = rf[vb][grp];
  assign opa    = sv ? scalar : a_el;
  assign in_len = (int'(grp) * NLANE + LANE) < int'(vl);
  assign active = ex_en && mbit && in_len;

  always_comb begin
    case (op)
      OP_ADD:  res = opa + b_el;
      OP_SUB:  res = opa - b_el;
      OP_MUL:  res = opa * b_el;
      default: res = opa;
    endcase
  end

  assign cmp_bit = (opa != b_el);
  assign cmp_act = active;
  assign rd_data = rf[rd_reg][rd_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NVREG; r++)
        for (int s = 0; s < SLOTS; s++)
          rf[r][s] <= '0;
    end else if (active && op != OP_CMPNE) begin
      rf[vd][grp] <= res;
    end else if (hw_en) begin
      rf[hw_reg][hw_slot] <= hw_data;
    end
  end
endmodule

// File: rtl/vx_mask_file.sv
module vx_mask_file #(
  parameter int NLANE = 4,
  parameter int MVL   = 32,
  parameter int NMASK = 8,
  localparam int SLOTS = MVL / NLANE,
  localparam int GW    = $clog2(SLOTS),
  localparam int MW    = $clog2(NMASK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [MW-1:0]    widx,
  input  logic [GW-1:0]    grp,
  input  logic [NLANE-1:0] wbits,
  input  logic [NLANE-1:0] wact,
  input  logic [MW-1:0]    ridx,
  output logic [NLANE-1:0] rbits,
  input  logic [MW-1:0]    hr_idx,
  output logic [MVL-1:0]   hr_mask
);
  logic [MVL-1:0] mf [NMASK];

  assign rbits   = mf[ridx][int'(grp) * NLANE +: NLANE];
  assign hr_mask = mf[hr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int m = 0; m < NMASK; m++) mf[m] <= '0;
    end else if (we) begin
      for (int l = 0; l < NLANE; l++)
        if (wact[l]) mf[widx][int'(grp) * NLANE + l] <= wbits[l];
    end
  end
endmodule

// File: rtl/vx_seq.sv
module vx_seq
  import vx_pkg::*;
#(
  parameter int NLANE = 4,
  parameter int MVL   = 32,
  parameter int EW    = 64,
  parameter int NVREG = 8,
  parameter int NMASK = 8,
  localparam int SLOTS = MVL / NLANE,
  localparam int GW    = $clog2(SLOTS),
  localparam int RW    = $clog2(NVREG),
  localparam int MW    = $clog2(NMASK),
  localparam int VLW   = $clog2(MVL) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vl_we,
  input  logic [VLW-1:0] vl_wdata,
  output logic [VLW-1:0] vl_cur,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_op,
  input  logic           in_sv,
  input  logic [RW-1:0]  in_vd,
  input  logic [RW-1:0]  in_va,
  input  logic [RW-1:0]  in_vb,
  input  logic [EW-1:0]  in_scalar,
  input  logic [MW:0]    in_msel,
  output logic           busy,
  output logic [GW-1:0]  grp,
  output logic           last,
  output logic [VLW-1:0] ex_vl,
  output vx_op_e         ex_op,
  output logic           ex_sv,
  output logic [RW-1:0]  ex_vd,
  output logic [RW-1:0]  ex_va,
  output logic [RW-1:0]  ex_vb,
  output logic [EW-1:0]  ex_scalar,
  output logic [MW:0]    ex_msel,
  output logic           done
);
  logic [VLW-1:0] vl_q, ngrp;
  logic           accept;

  assign vl_cur   = vl_q;
  assign in_ready = !busy;
  assign accept   = in_valid && !busy;
  assign ngrp     = (ex_vl + VLW'(NLANE - 1)) / VLW'(NLANE);
  assign last     = (VLW'(grp) == ngrp - VLW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            vl_q <= VLW'(MVL);
    else if (vl_we)        vl_q <= (vl_wdata > VLW'(MVL)) ? VLW'(MVL) : vl_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      grp       <= '0;
      done      <= 1'b0;
      ex_vl     <= '0;
      ex_op     <= OP_ADD;
      ex_sv     <= 1'b0;
      ex_vd     <= '0;
      ex_va     <= '0;
      ex_vb     <= '0;
      ex_scalar <= '0;
      ex_msel   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        ex_vl     <= vl_q;
        ex_op     <= vx_op_e'(in_op);
        ex_sv     <= in_sv;
        ex_vd     <= in_vd;
        ex_va     <= in_va;
        ex_vb     <= in_vb;
        ex_scalar <= in_scalar;
        ex_msel   <= in_msel;
        grp       <= '0;
        if (vl_q == '0) done <= 1'b1;
        else            busy <= 1'b1;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          grp  <= '0;
        end else begin
          grp <= grp + GW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vx_unit.sv
module vx_unit
  import vx_pkg::*;
#(
  parameter int NLANE = 4,
  parameter int MVL   = 32,
  parameter int EW    = 64,
  parameter int NVREG = 8,
  parameter int NMASK = 8,
  localparam int SLOTS = MVL / NLANE,
  localparam int GW    = $clog2(SLOTS),
  localparam int RW    = $clog2(NVREG),
  localparam int MW    = $clog2(NMASK),
  localparam int VLW   = $clog2(MVL) + 1,
  localparam int IXW   = $clog2(MVL),
  localparam int LW    = $clog2(NLANE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vl_we,
  input  logic [VLW-1:0] vl_wdata,
  output logic [VLW-1:0] vl_cur,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_op,
  input  logic           in_sv,
  input  logic [RW-1:0]  in_vd,
  input  logic [RW-1:0]  in_va,
  input  logic [RW-1:0]  in_vb,
  input  logic [EW-1:0]  in_scalar,
  input  logic [MW:0]    in_msel,
  output logic           done,
  input  logic           hw_en,
  input  logic [RW-1:0]  hw_reg,
  input  logic [IXW-1:0] hw_idx,
  input  logic [EW-1:0]  hw_data,
  input  logic [RW-1:0]  rd_reg,
  input  logic [IXW-1:0] rd_idx,
  output logic [EW-1:0]  rd_data,
  input  logic [MW-1:0]  rd_mreg,
  output logic [MVL-1:0] rd_mask
);
  logic           busy, last, ex_sv;
  logic [GW-1:0]  grp;
  logic [VLW-1:0] ex_vl;
  vx_op_e         ex_op;
  logic [RW-1:0]  ex_vd, ex_va, ex_vb;
  logic [EW-1:0]  ex_scalar;
  logic [MW:0]    ex_msel;

  logic [NLANE-1:0] mgrp, mbit, cbit, cact;
  logic [EW-1:0]    rd_lane [NLANE];

  vx_seq #(.NLANE(NLANE), .MVL(MVL), .EW(EW), .NVREG(NVREG), .NMASK(NMASK)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .vl_we(vl_we), .vl_wdata(vl_wdata), .vl_cur(vl_cur),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sv(in_sv), .in_vd(in_vd), .in_va(in_va), .in_vb(in_vb),
    .in_scalar(in_scalar), .in_msel(in_msel),
    .busy(busy), .grp(grp), .last(last), .ex_vl(ex_vl), .ex_op(ex_op),
    .ex_sv(ex_sv), .ex_vd(ex_vd), .ex_va(ex_va), .ex_vb(ex_vb),
    .ex_scalar(ex_scalar), .ex_msel(ex_msel), .done(done)
  );

  vx_mask_file #(.NLANE(NLANE), .MVL(MVL), .NMASK(NMASK)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .we(busy && ex_op == OP_CMPNE), .widx(MW'(ex_vd)), .grp(grp),
    .wbits(cbit), .wact(cact),
    .ridx(ex_msel[MW-1:0]), .rbits(mgrp),
    .hr_idx(rd_mreg), .hr_mask(rd_mask)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign mbit[l] = ex_msel[MW] | mgrp[l];

    vx_lane #(.LANE(l), .NLANE(NLANE), .MVL(MVL), .EW(EW), .NVREG(NVREG)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .ex_en(busy), .grp(grp), .vl(ex_vl), .op(ex_op), .sv(ex_sv),
      .vd(ex_vd), .va(ex_va), .vb(ex_vb), .scalar(ex_scalar), .mbit(mbit[l]),
      .hw_en(hw_en && !busy && hw_idx[LW-1:0] == LW'(l)),
      .hw_reg(hw_reg), .hw_slot(hw_idx[IXW-1:LW]), .hw_data(hw_data),
      .rd_reg(rd_reg), .rd_slot(rd_idx[IXW-1:LW]), .rd_data(rd_lane[l]),
      .cmp_bit(cbit[l]), .cmp_act(cact[l])
    );
  end

  assign rd_data = rd_lane[rd_idx[LW-1:0]];
endmodule

// File: rtl/vx_unit_chk.sv
module vx_unit_chk #(
  parameter int NLANE = 4,
  parameter int MVL   = 32,
  parameter int VLW   = 6,
  parameter int GW    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           done,
  input logic           busy,
  input logic           last,
  input logic [GW-1:0]  grp,
  input logic [VLW-1:0] vl_cur,
  input logic [VLW-1:0] ex_vl
);
  AST_VL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    vl_cur <= VLW'(MVL)); // R1

  AST_ZERO_VL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && vl_cur == '0) |=> (done && in_ready)); // R8

  AST_LAST_GROUP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> (done && in_ready)); // R7

  AST_READY_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> done); // R7

  AST_GROUP_IN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(grp) * NLANE < int'(ex_vl))); // R6
endmodule

bind vx_unit vx_unit_chk #(.NLANE(NLANE), .MVL(MVL), .VLW(VLW), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .busy(busy), .last(last), .grp(grp),
  .vl_cur(vl_cur), .ex_vl(ex_vl)
);

// File: tb/sim_vx_unit.sv
module sim_vx_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        vl_we = 0;
  logic [5:0]  vl_wdata = 0, vl_cur;
  logic        in_valid = 0, in_ready, in_sv = 0, done;
  logic [1:0]  in_op = 0;
  logic [2:0]  in_vd = 0, in_va = 0, in_vb = 0;
  logic [63:0] in_scalar = 0;
  logic [3:0]  in_msel = 4'h8;
  logic        hw_en = 0;
  logic [2:0]  hw_reg = 0, rd_reg = 0, rd_mreg = 0;
  logic [4:0]  hw_idx = 0, rd_idx = 0;
  logic [63:0] hw_data = 0, rd_data;
  logic [31:0] rd_mask;

  vx_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, acc_cyc = 0, mvl = 32;
  int exp_q[$];
  logic [63:0] mv [8][32];
  logic [31:0] mm [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected done", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check((cyc - acc_cyc) == e, "R7 done latency", 64'(cyc - acc_cyc), 64'(e));
      end
    end
  end

  task automatic host_wr(input int r, input int i, input logic [63:0] d);
    @(negedge clk);
    hw_en = 1; hw_reg = 3'(r); hw_idx = 5'(i); hw_data = d;
    @(negedge clk);
    hw_en = 0;
    mv[r][i] = d;
  endtask

  task automatic set_vl(input int v);
    @(negedge clk);
    vl_we = 1; vl_wdata = 6'(v);
    @(negedge clk);
    vl_we = 0;
    mvl = (v > 32) ? 32 : v;
  endtask

  task automatic check_vreg(input int r, input string req);
    int bad = -1;
    for (int i = 0; i < 32; i++) begin
      rd_reg = 3'(r); rd_idx = 5'(i); #1;
      if (rd_data !== mv[r][i] && bad < 0) bad = i;
    end
    if (bad < 0) check(1, req, 0, 0);
    else begin
      rd_idx = 5'(bad); #1;
      check(0, $sformatf("%s v%0d[%0d]", req, r, bad), rd_data, mv[r][bad]);
    end
  endtask

  task automatic check_mreg(input int m, input string req);
    rd_mreg = 3'(m); #1;
    check(rd_mask === mm[m], $sformatf("%s m%0d", req, m), 64'(rd_mask), 64'(mm[m]));
  endtask

  task automatic run(input int op, input bit sv, input int vd, input int va, input int vb,
                     input logic [63:0] sc, input logic [3:0] msel, input string req,
                     input bit poke = 0);
    logic [63:0] nv [32];
    logic [31:0] nm;
    for (int i = 0; i < 32; i++) nv[i] = mv[vd][i];
    nm = mm[vd];
    for (int i = 0; i < mvl; i++) begin
      logic [63:0] a, b;
      bit en;
      en = msel[3] || mm[msel[2:0]][i];
      a = sv ? sc : mv[va][i];
      b = mv[vb][i];
      if (en) begin
        case (op)
          0: nv[i] = a + b;
          1: nv[i] = a - b;
          2: nv[i] = a * b;
          default: nm[i] = (a != b);
        endcase
      end
    end
    exp_q.push_back((mvl + 3) / 4);
    @(negedge clk);
    in_valid = 1; in_op = 2'(op); in_sv = sv; in_vd = 3'(vd); in_va = 3'(va);
    in_vb = 3'(vb); in_scalar = sc; in_msel = msel;
    @(posedge clk);
    #1 acc_cyc = cyc; in_valid = 0;
    if (poke) begin
      @(negedge clk);
      check(in_ready == 0, "R7 ready low while busy", 64'(in_ready), 0);
      hw_en = 1; hw_reg = 3'd7; hw_idx = 5'd5; hw_data = 64'hDEAD_BEEF;
      @(negedge clk);
      hw_en = 0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    if (op == 3) begin mm[vd] = nm; check_mreg(vd, req); end
    else begin for (int i = 0; i < 32; i++) mv[vd][i] = nv[i]; check_vreg(vd, req); end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) begin
      mm[r] = 0;
      for (int i = 0; i < 32; i++) mv[r][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(vl_cur == 6'd32, "R1 reset length", 64'(vl_cur), 32);
    check_vreg(3, "R9 reset clears vector");
    check_mreg(0, "R9 reset clears mask");

    for (int i = 0; i < 32; i++) begin
      logic [63:0] x;
      x = 64'h0123_4567_89AB_CDEF * 64'(i + 1);
      host_wr(1, i, x);
      host_wr(2, i, (i % 3 == 0) ? x : 64'(i) * 64'h1111 + 64'd7);
    end
    check_vreg(1, "R9 idle write");

    run(0, 0, 3, 1, 2, 0, 4'h8, "R2 add full length");
    set_vl(10);
    run(1, 0, 4, 1, 2, 0, 4'h8, "R2 R6 sub length 10");
    set_vl(7);
    run(2, 0, 5, 1, 2, 0, 4'h8, "R2 R6 mul length 7");
    set_vl(32);
    run(1, 1, 3, 0, 1, 64'd1000, 4'h8, "R3 scalar minus vector");
    run(2, 1, 4, 0, 2, 64'hFFFF_FFFF_0000_0003, 4'h8, "R3 scalar times vector");
    run(3, 0, 2, 1, 2, 0, 4'h8, "R4 compare not-equal");
    run(1, 0, 6, 1, 2, 0, 4'h2, "R5 masked subtract");
    run(0, 0, 6, 6, 1, 0, 4'hA, "R5 unmasked with msel bit3");
    set_vl(13);
    run(3, 0, 2, 2, 1, 0, 4'h8, "R4 R6 short compare keeps upper bits");
    set_vl(40);
    check(vl_cur == 6'd32, "R1 clamp", 64'(vl_cur), 32);
    set_vl(0);
    run(0, 0, 3, 1, 2, 0, 4'h8, "R8 zero length no write");
    set_vl(32);
    run(0, 0, 5, 1, 1, 0, 4'h8, "R2 R7 long op with poke", 1);
    check_vreg(7, "R9 write while busy ignored");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule